// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Sequencer

This block is the digital sequencer behind a capacitive touch front end. It produces a train of charge-transfer pulses on a prescaled pulse clock. Each pulse has a high phase and a low phase, and the length of each phase is programmed separately. Up to eight sensor groups are measured at the same time. Every enabled group counts the pulses that end while its sampling comparator input is still low. When the comparator reads high, the group is marked complete and its count is kept for software to read.

An acquisition starts from a start bit in the control word. The start can be immediate, or it can wait for a condition on an external synchronisation input. The acquisition ends when all enabled groups are complete, or when any group counter reaches the selected maximum. The ending sets a done flag, and the maximum case also sets an error flag. Both flags can be masked onto a single interrupt line. Between acquisitions, an output tells the pad logic whether to drive the sensing pads low or to leave them floating.

Top module: `touch_acq_seq`

## Requirements
- R1: After reset every readable register reads 0, `pulse_hi` and `irq` are 0, and `io_park_low` is 1.
- R2: While running, `pulse_hi` stays high for (HI+1)·2^P system cycles and low for (LO+1)·2^P cycles. HI is control bits [11:8], LO is bits [15:12] and P is bits [6:4].
- R3: A start request (control bit 0 written as 1) is refused if any of these holds: P=0 with LO<2, P=1 with LO=0, or maximum code (bits [18:16]) equal to 7. A refused start leaves control bit 0 reading 0, and no pulse appears.
- R4: With sync mode off (control bit 1 = 0), `pulse_hi` is high in the first cycle after the write that starts the acquisition.
- R5: With sync mode on, the acquisition waits while control bit 0 reads 1. With polarity 0 (control bit 2), it begins after a falling edge of `sync_in`. With polarity 1, it begins once `sync_in` is high.
- R6: An enabled group (address 3, bit i) adds 1 for each pulse that ends while `cmp_in[i]` is low. When a pulse ends with `cmp_in[i]` high, the group sets its completion bit (address 3, bit 16+i) and its count (address 8+i) freezes.
- R7: A group that is not enabled keeps count 0 and completion 0, whatever its comparator input does.
- R8: When every enabled group is complete, the done flag (address 2, bit 0) sets and control bit 0 clears.
- R9: The limit is 2^(8+M)−1 for maximum code M. When a group count reaches the limit first, the acquisition ends with both the done flag and the error flag (address 2, bit 1) set, and that count reads the limit.
- R10: `irq` = (done AND enable bit 0 at address 1) OR (error AND enable bit 1 at address 1). Writing 1 to a bit at address 2 clears that flag, and writing 0 leaves it unchanged.
- R11: Writing control bit 0 as 0 during a wait or a run stops the block at once, with no flag set.
- R12: `io_park_low` is 1 outside a run when the float bit (control bit 3) is 0. It is 0 during a run or when the float bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for writes and reads |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| sync_in | input | 1 | External synchronisation input |
| cmp_in | input | 8 | Per-group sampling comparator inputs |
| pulse_hi | output | 1 | Charge-transfer phase, high during the high phase |
| io_park_low | output | 1 | Drive sensing pads low while idle |
| irq | output | 1 | Masked interrupt |

## Verification
The bench uses the default parameters: eight groups and 14-bit counters. All eight groups run side by side, and the completion field and the count addresses are checked over their full span. A 14-bit counter permits every limit code, but the run budget only reaches the limits for codes 0 and 1 (255 and 511). For that reason, the saturation and error paths are tested at those two limits. The table of vectors covers prescaler settings 0 to 3, including the minimum low phase that each setting accepts.

// File: rtl/touch_acq_seq.sv
module touch_acq_seq #(
  parameter int NGRP   = 8,
  parameter int CNT_W  = 14,
  parameter int PSC_W  = 3,
  parameter int LEN_W  = 4,
  parameter int MAXC_W = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              sync_in,
  input  logic [NGRP-1:0]   cmp_in,
  output logic              pulse_hi,
  output logic              io_park_low,
  output logic              irq
);

  localparam int DIV_W    = (1 << PSC_W) - 1;
  localparam int GI_W     = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int CNT_BASE = 8;
  localparam int F_SYNC   = 1;
  localparam int F_POL    = 2;
  localparam int F_FLOAT  = 3;
  localparam int F_PSC    = 4;
  localparam int F_HI     = 8;
  localparam int F_LO     = 12;
  localparam int F_MAXC   = 16;
  localparam int F_END    = F_MAXC + MAXC_W;
  localparam int DONE_POS = 16;
  localparam logic [MAXC_W-1:0] MAXC_TOP = MAXC_W'(CNT_W - 8);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;
  st_t st;

  logic              ctrl_start, sync_mode, sync_pol, idle_float;
  logic [PSC_W-1:0]  psc;
  logic [LEN_W-1:0]  hi_len, lo_len;
  logic [MAXC_W-1:0] mcode;
  logic              ie_done, ie_err, flag_done, flag_err;
  logic [NGRP-1:0]   grp_en, grp_done;
  logic [CNT_W-1:0]  cnt [NGRP];
  logic              sync_q, phase_hi;
  logic [DIV_W-1:0]  div_cnt;
  logic [LEN_W-1:0]  ph_cnt;

  logic unused_wbits;
  assign unused_wbits = ^cfg_wdata[DATA_W-1:F_END];

  wire wr_ctrl = cfg_we && (cfg_addr == ADDR_W'(0));
  wire wr_ien  = cfg_we && (cfg_addr == ADDR_W'(1));
  wire wr_clr  = cfg_we && (cfg_addr == ADDR_W'(2));
  wire wr_grp  = cfg_we && (cfg_addr == ADDR_W'(3));
  wire busy    = (st != S_IDLE);

  wire [PSC_W-1:0]  w_psc  = cfg_wdata[F_PSC +: PSC_W];
  wire [LEN_W-1:0]  w_lo   = cfg_wdata[F_LO +: LEN_W];
  wire [MAXC_W-1:0] w_maxc = cfg_wdata[F_MAXC +: MAXC_W];
  wire              w_sync = cfg_wdata[F_SYNC];

  logic w_lo_ok;
  always_comb begin
    if (w_psc == PSC_W'(0))      w_lo_ok = (w_lo >= LEN_W'(2));
    else if (w_psc == PSC_W'(1)) w_lo_ok = (w_lo >= LEN_W'(1));
    else                         w_lo_ok = 1'b1;
  end

  wire w_ok      = w_lo_ok && (w_maxc <= MAXC_TOP);
  wire start_req = wr_ctrl && cfg_wdata[0] && !busy && w_ok;
  wire abort     = wr_ctrl && !cfg_wdata[0] && busy;
  wire sync_hit  = sync_pol ? sync_in : (sync_q && !sync_in);
  wire run_go    = (start_req && !w_sync) || ((st == S_WAIT) && sync_hit && !abort);

  logic [DIV_W-1:0] psc_mask;
  logic [CNT_W-1:0] max_val;
  assign psc_mask = ~({DIV_W{1'b1}} << psc);
  assign max_val  = {CNT_W{1'b1}} >> (MAXC_TOP - mcode);

  wire tick      = (div_cnt & psc_mask) == psc_mask;
  wire ph_last   = (ph_cnt == (phase_hi ? hi_len : lo_len));
  wire pulse_end = (st == S_RUN) && tick && !phase_hi && ph_last;

  logic [NGRP-1:0] g_eval, g_fin, g_inc, g_hit, g_after;
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      g_eval[g]  = pulse_end && grp_en[g] && !grp_done[g];
      g_fin[g]   = g_eval[g] && cmp_in[g];
      g_inc[g]   = g_eval[g] && !cmp_in[g];
      g_hit[g]   = g_inc[g] && (CNT_W'(cnt[g] + 1'b1) == max_val);
      g_after[g] = !grp_en[g] || grp_done[g] || g_fin[g];
    end
  end

  wire any_hit = |g_hit;
  wire finish  = pulse_end && !abort && ((&g_after) || any_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_start <= 1'b0;
      sync_mode  <= 1'b0;
      sync_pol   <= 1'b0;
      idle_float <= 1'b0;
      psc        <= '0;
      hi_len     <= '0;
      lo_len     <= '0;
      mcode      <= '0;
      ie_done    <= 1'b0;
      ie_err     <= 1'b0;
      grp_en     <= '0;
      flag_done  <= 1'b0;
      flag_err   <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (wr_ctrl && !busy) begin
        sync_mode  <= cfg_wdata[F_SYNC];
        sync_pol   <= cfg_wdata[F_POL];
        idle_float <= cfg_wdata[F_FLOAT];
        psc        <= w_psc;
        hi_len     <= cfg_wdata[F_HI +: LEN_W];
        lo_len     <= w_lo;
        mcode      <= w_maxc;
      end
      if (start_req)            ctrl_start <= 1'b1;
      else if (abort || finish) ctrl_start <= 1'b0;
      if (wr_ien) begin
        ie_done <= cfg_wdata[0];
        ie_err  <= cfg_wdata[1];
      end
      if (wr_grp && !busy) grp_en <= cfg_wdata[NGRP-1:0];
      flag_done <= finish | (flag_done & !(wr_clr && cfg_wdata[0]));
      flag_err  <= (finish && any_hit) | (flag_err & !(wr_clr && cfg_wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (start_req) st <= w_sync ? S_WAIT : S_RUN;
        S_WAIT:  if (abort) st <= S_IDLE; else if (sync_hit) st <= S_RUN;
        S_RUN:   if (abort || finish) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      phase_hi <= 1'b0;
      ph_cnt   <= '0;
    end else if (run_go) begin
      div_cnt  <= '0;
      phase_hi <= 1'b1;
      ph_cnt   <= '0;
    end else if (st == S_RUN) begin
      div_cnt <= div_cnt + 1'b1;
      if (tick) begin
        if (ph_last) begin
          phase_hi <= !phase_hi;
          ph_cnt   <= '0;
        end else begin
          ph_cnt <= ph_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_done <= '0;
      for (int g = 0; g < NGRP; g++) cnt[g] <= '0;
    end else if (run_go) begin
      grp_done <= '0;
      for (int g = 0; g < NGRP; g++) cnt[g] <= '0;
    end else begin
      grp_done <= grp_done | g_fin;
      for (int g = 0; g < NGRP; g++)
        if (g_inc[g]) cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign pulse_hi    = (st == S_RUN) && phase_hi;
  assign io_park_low = (st != S_RUN) && !idle_float;
  assign irq         = (flag_done && ie_done) || (flag_err && ie_err);

  wire [GI_W-1:0] gidx = GI_W'(cfg_addr - ADDR_W'(CNT_BASE));

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == ADDR_W'(0)) begin
      cfg_rdata[0]                 = ctrl_start;
      cfg_rdata[F_SYNC]            = sync_mode;
      cfg_rdata[F_POL]             = sync_pol;
      cfg_rdata[F_FLOAT]           = idle_float;
      cfg_rdata[F_PSC +: PSC_W]    = psc;
      cfg_rdata[F_HI +: LEN_W]     = hi_len;
      cfg_rdata[F_LO +: LEN_W]     = lo_len;
      cfg_rdata[F_MAXC +: MAXC_W]  = mcode;
    end else if (cfg_addr == ADDR_W'(1)) begin
      cfg_rdata[0] = ie_done;
      cfg_rdata[1] = ie_err;
    end else if (cfg_addr == ADDR_W'(2)) begin
      cfg_rdata[0] = flag_done;
      cfg_rdata[1] = flag_err;
    end else if (cfg_addr == ADDR_W'(3)) begin
      cfg_rdata[NGRP-1:0]            = grp_en;
      cfg_rdata[DONE_POS +: NGRP]    = grp_done;
    end else if (int'(cfg_addr) >= CNT_BASE && int'(cfg_addr) < CNT_BASE + NGRP) begin
      cfg_rdata[CNT_W-1:0] = cnt[gidx];
    end
  end

  // R3
  start_cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_start |-> ((mcode <= MAXC_TOP) && !(psc == PSC_W'(0) && lo_len < LEN_W'(2))
                    && !(psc == PSC_W'(1) && lo_len == LEN_W'(0))));

  // R8
  done_drops_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> !ctrl_start);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err) |-> flag_done);

  // R12
  pads_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_hi |-> !io_park_low);

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R6
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done[g] && $past(grp_done[g])) |-> $stable(cnt[g]));
    // R9
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN) |-> (cnt[g] <= max_val));
  end

endmodule

// File: tb/sim_touch_acq_seq.sv
module sim_touch_acq_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        sync_in;
  logic [7:0]  cmp_in;
  logic        pulse_hi, io_park_low, irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  touch_acq_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sync_in(sync_in),
    .cmp_in(cmp_in), .pulse_hi(pulse_hi), .io_park_low(io_park_low), .irq(irq)
  );

  // rows: {psc[3], hi[4], lo[4], maxc[3], enables[8], per-group trip pulse (8 bits each, 0 = never)}
  localparam logic [85:0] VEC [6] = '{
    {3'd0, 4'd0, 4'd2, 3'd0, 8'h0F, 64'h00000000_02050103},
    {3'd1, 4'd3, 4'd1, 3'd0, 8'hA5, 64'h09010201_01070104},
    {3'd2, 4'd1, 4'd0, 3'd0, 8'h01, 64'h03030303_03030306},
    {3'd0, 4'd1, 4'd3, 3'd0, 8'h03, 64'h00000000_00000A00},
    {3'd3, 4'd0, 4'd0, 3'd0, 8'hFF, 64'h08070605_04030201},
    {3'd0, 4'd0, 4'd2, 3'd1, 8'h80, 64'h00000000_00000000}
  };

  function automatic logic [31:0] mk_ctrl(input logic st, sy, pol, flt,
      input logic [2:0] p, input logic [3:0] h, l, input logic [2:0] m);
    return {13'b0, m, l, h, 1'b0, p, flt, pol, sy, st};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [85:0] v;
    logic [2:0]  psc, mc;
    logic [3:0]  hi, lo;
    logic [7:0]  en, k;
    logic [63:0] thr;
    logic [31:0] d, grp;
    int hw, lw, fe, stage, cyc, mx, ecnt;
    logic prev, ph, fl, done, experr, edone;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sync_in = 1'b0; cmp_in = '0;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(2);

    // R1 reset state
    rd(4'd0, d); chk("R1", "ctrl", d, 0);
    rd(4'd1, d); chk("R1", "ien", d, 0);
    rd(4'd2, d); chk("R1", "flags", d, 0);
    rd(4'd3, d); chk("R1", "groups", d, 0);
    rd(4'd8, d); chk("R1", "count0", d, 0);
    chk("R1", "pulse_hi", {31'b0, pulse_hi}, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "io_park_low", {31'b0, io_park_low}, 1);

    // R3 refused configurations
    wr(4'd0, mk_ctrl(1, 0, 0, 0, 3'd0, 4'd0, 4'd1, 3'd0));
    idle_cycles(6);
    rd(4'd0, d); chk("R3", "psc0 lo1 start", {31'b0, d[0]}, 0);
    chk("R3", "psc0 lo1 pulse", {31'b0, pulse_hi}, 0);
    wr(4'd0, mk_ctrl(1, 0, 0, 0, 3'd1, 4'd0, 4'd0, 3'd0));
    idle_cycles(6);
    rd(4'd0, d); chk("R3", "psc1 lo0 start", {31'b0, d[0]}, 0);
    chk("R3", "psc1 lo0 pulse", {31'b0, pulse_hi}, 0);
    wr(4'd0, mk_ctrl(1, 0, 0, 0, 3'd2, 4'd0, 4'd0, 3'd7));
    idle_cycles(6);
    rd(4'd0, d); chk("R3", "maxc7 start", {31'b0, d[0]}, 0);
    chk("R3", "maxc7 pulse", {31'b0, pulse_hi}, 0);

    // table walk: R2 R4 R6 R7 R8 R9
    for (int r = 0; r < 6; r++) begin
      v = VEC[r];
      psc = v[85:83]; hi = v[82:79]; lo = v[78:75]; mc = v[74:72];
      en = v[71:64]; thr = v[63:0];
      cmp_in = '0;
      wr(4'd3, {24'b0, en});
      wr(4'd0, mk_ctrl(1, 0, 0, 0, psc, hi, lo, mc));
      cfg_addr = 4'd2;
      #1;
      chk("R4", $sformatf("row%0d immediate pulse", r), {31'b0, pulse_hi}, 1);
      prev = 1'b1; fe = 0; hw = 0; lw = 0; stage = 0; cyc = 0; done = 1'b0;
      while (!done && cyc < 5000) begin
        ph = pulse_hi;
        fl = cfg_rdata[0];
        if (stage == 0 && ph) hw++;
        else if (stage == 0) begin stage = 1; lw = 1; end
        else if (stage == 1 && !ph && !fl) lw++;
        else if (stage == 1) stage = 2;
        if (prev && !ph) begin
          fe++;
          for (int g = 0; g < 8; g++)
            if (int'(thr[g*8 +: 8]) == fe) cmp_in[g] = 1'b1;
        end
        prev = ph;
        done = fl;
        cyc++;
        @(negedge clk);
        #1;
      end
      chk("R2", $sformatf("row%0d high width", r), hw, (int'(hi) + 1) << psc);
      chk("R2", $sformatf("row%0d low width", r), lw, (int'(lo) + 1) << psc);
      mx = (1 << (8 + int'(mc))) - 1;
      experr = 1'b0;
      rd(4'd3, grp);
      for (int g = 0; g < 8; g++) begin
        k = thr[g*8 +: 8];
        if (!en[g]) begin
          ecnt = 0; edone = 1'b0;
        end else if (k != 0 && int'(k) - 1 < mx) begin
          ecnt = int'(k) - 1; edone = 1'b1;
        end else begin
          ecnt = mx; edone = 1'b0; experr = 1'b1;
        end
        rd(4'(8 + g), d);
        if (!en[g]) begin
          chk("R7", $sformatf("row%0d g%0d count", r, g), d, ecnt);
          chk("R7", $sformatf("row%0d g%0d complete", r, g), {31'b0, grp[16+g]}, 0);
        end else if (edone) begin
          chk("R6", $sformatf("row%0d g%0d count", r, g), d, ecnt);
          chk("R6", $sformatf("row%0d g%0d complete", r, g), {31'b0, grp[16+g]}, 1);
        end else begin
          chk("R9", $sformatf("row%0d g%0d saturated count", r, g), d, ecnt);
          chk("R9", $sformatf("row%0d g%0d complete", r, g), {31'b0, grp[16+g]}, 0);
        end
      end
      rd(4'd2, d);
      chk("R8", $sformatf("row%0d done flag", r), {31'b0, d[0]}, 1);
      chk("R9", $sformatf("row%0d error flag", r), {31'b0, d[1]}, {31'b0, experr});
      rd(4'd0, d);
      chk("R8", $sformatf("row%0d start cleared", r), {31'b0, d[0]}, 0);
      wr(4'd2, 32'h3);
      rd(4'd2, d);
      chk("R10", $sformatf("row%0d flags cleared", r), d, 0);
    end
    cmp_in = '0;

    // R5 sync polarity 0: falling edge
    wr(4'd3, 32'h01);
    sync_in = 1'b1;
    wr(4'd0, mk_ctrl(1, 1, 0, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    idle_cycles(8);
    chk("R5", "pol0 waits while high", {31'b0, pulse_hi}, 0);
    rd(4'd0, d); chk("R5", "pol0 start held", {31'b0, d[0]}, 1);
    chk("R12", "pads parked while waiting", {31'b0, io_park_low}, 1);
    sync_in = 1'b0;
    @(negedge clk);
    chk("R5", "pol0 begins after fall", {31'b0, pulse_hi}, 1);
    chk("R12", "pads released in run", {31'b0, io_park_low}, 0);
    // R11 abort
    wr(4'd0, mk_ctrl(0, 1, 0, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    chk("R11", "abort stops pulses", {31'b0, pulse_hi}, 0);
    idle_cycles(10);
    rd(4'd2, d); chk("R11", "abort no flags", d, 0);
    rd(4'd0, d); chk("R11", "abort start clear", {31'b0, d[0]}, 0);
    chk("R12", "pads parked after abort", {31'b0, io_park_low}, 1);

    // R5 sync polarity 1: high level
    sync_in = 1'b0;
    wr(4'd0, mk_ctrl(1, 1, 1, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    idle_cycles(6);
    chk("R5", "pol1 waits while low", {31'b0, pulse_hi}, 0);
    sync_in = 1'b1;
    @(negedge clk);
    chk("R5", "pol1 begins on high", {31'b0, pulse_hi}, 1);
    wr(4'd0, mk_ctrl(0, 1, 1, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    chk("R11", "pol1 abort", {31'b0, pulse_hi}, 0);
    sync_in = 1'b0;
    wr(4'd0, mk_ctrl(0, 0, 0, 1, 3'd0, 4'd0, 4'd2, 3'd0));
    chk("R12", "float idle releases pads", {31'b0, io_park_low}, 0);

    // R10 interrupt masking, R6 comparator already high
    wr(4'd1, 32'h1);
    cmp_in = 8'h01;
    wr(4'd0, mk_ctrl(1, 0, 0, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    idle_cycles(10);
    chk("R10", "irq on done", {31'b0, irq}, 1);
    rd(4'd8, d); chk("R6", "pre-tripped count", d, 0);
    wr(4'd2, 32'h1);
    chk("R10", "irq after clear", {31'b0, irq}, 0);
    wr(4'd1, 32'h2);
    cmp_in = 8'h00;
    wr(4'd0, mk_ctrl(1, 0, 0, 0, 3'd0, 4'd0, 4'd2, 3'd0));
    idle_cycles(1100);
    chk("R10", "irq on error", {31'b0, irq}, 1);
    rd(4'd2, d); chk("R9", "both flags", d, 3);
    wr(4'd2, 32'h2);
    rd(4'd2, d); chk("R10", "selective clear", d, 1);
    chk("R10", "done masked", {31'b0, irq}, 0);
    wr(4'd2, 32'h1);

    finish_run();
  end
endmodule